// File: doc/BRIEF.md
# External interrupt polarity conditioner

This block sits between a small number of external interrupt pins (two by default) and a downstream interrupt controller that only accepts active-high levels or rising edges. Software programs each line through a 32-bit register port. The settings are an enable, a choice between level and edge sensing, and a polarity bit. The block synchronises each pin to its clock. It inverts the pin where the selected sense is low-active or falling, and gates the result with the enable bit. Each line has its own output to the downstream controller, so that controller is always set for high level or rising edge.

Each line's setting is kept in its own configuration register. Those registers read back exactly the bits that were written, so software can save and restore them. A read-only status word reports the input filter as ready. Filter timing and write-protection registers are not modelled: their offsets read as zero and ignore writes.

Top module: `extirq_cond`

## Requirements
- R1: After reset every configuration register reads 0x00000000 and every output `irqOut` is low.
- R2: The configuration register of line n is at byte offset 0x4 + 4*n. It keeps only bit 16 (enable), bit 9 (1 = level, 0 = edge) and bit 8 (polarity). It reads back those three bits as written, and every other bit reads 0.
- R3: Offset 0x0 is a read-only status word whose low NUM_LINES bits read 1 and whose other bits read 0. Writes to it change nothing.
- R4: With enable=1, level=1, polarity=1 (active-high level), `irqOut[n]` equals the pin level.
- R5: With enable=1, level=1, polarity=0 (active-low level), `irqOut[n]` is the inverse of the pin level.
- R6: With enable=1, level=0, polarity=0 (rising edge), `irqOut[n]` follows the pin, so a rising pin gives a rising output.
- R7: With enable=1, level=0, polarity=1 (falling edge), `irqOut[n]` is the inverse of the pin, so a falling pin gives a rising output.
- R8: While enable=0, `irqOut[n]` stays low whatever the pin does. Clearing the enable drives the output low on the clock edge that takes the write.
- R9: A write to one line's configuration register leaves every other line's register and output unchanged.
- R10: Reads of any offset other than the status word and the configuration registers return 0. Writes to such offsets change no register and no output.
- R11: A pin change reaches `irqOut` after exactly two rising clock edges. After one edge the output still shows the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe, sampled on the rising clock edge |
| busAddr | input | ADDR_W (8) | Byte offset of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr`, combinational |
| pinIn | input | NUM_LINES (2) | External interrupt pins, asynchronous |
| irqOut | output | NUM_LINES (2) | Conditioned interrupts to the downstream controller |

## Verification
The assertions assume that the pins change no more than once per clock period and never near the rising edge. They also assume that the bus address and write strobe are steady across each edge. The latency check depends on the pin value captured at an edge being the one the synchroniser takes. The bench meets these assumptions by driving the pins and the bus only on the falling clock edge. It also holds each pin for at least two cycles before it checks the output.

// File: rtl/extirq_cond_pkg.sv
package extirq_cond_pkg;

  localparam int DATA_W    = 32;
  localparam int MAX_LINES = 8;

  // bit positions inside a line configuration word
  localparam int EN_POS  = 16;
  localparam int LVL_POS = 9;
  localparam int POL_POS = 8;

  typedef struct packed {
    logic en;
    logic lvl;
    logic pol;
  } lineCfg_t;

  // strobes handed from control to datapath
  typedef struct packed {
    logic [MAX_LINES-1:0] cfgWr;
    lineCfg_t             wrCfg;
  } ctrlStrobe_t;

  function automatic logic [DATA_W-1:0] cfgToWord(input lineCfg_t c);
    logic [DATA_W-1:0] w;
    w          = '0;
    w[EN_POS]  = c.en;
    w[LVL_POS] = c.lvl;
    w[POL_POS] = c.pol;
    return w;
  endfunction

  function automatic lineCfg_t wordToCfg(input logic [DATA_W-1:0] w);
    lineCfg_t c;
    c.en  = w[EN_POS];
    c.lvl = w[LVL_POS];
    c.pol = w[POL_POS];
    return c;
  endfunction

endpackage

// File: rtl/extirq_cond_ctrl.sv
module extirq_cond_ctrl
  import extirq_cond_pkg::*;
#(
  parameter int NUM_LINES = 2,
  parameter int ADDR_W    = 8
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            busWrEn,
  input  logic [ADDR_W-1:0]               busAddr,
  input  logic [DATA_W-1:0]               busWdata,
  input  lineCfg_t [NUM_LINES-1:0]        cfgQ,
  output ctrlStrobe_t                     strobe,
  output logic [DATA_W-1:0]               busRdata
);

  localparam int CFG_BASE = 4;
  localparam int CFG_STEP = 4;

  logic                 statusHit;
  logic [NUM_LINES-1:0] lineHit;
  logic                 anyHit;

  assign statusHit = (busAddr == '0);

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_dec
    localparam logic [ADDR_W-1:0] LINE_OFS = ADDR_W'(CFG_BASE + CFG_STEP * i);
    assign lineHit[i] = (busAddr == LINE_OFS);
  end

  assign anyHit = statusHit | (|lineHit);

  always_comb begin
    strobe       = '0;
    strobe.wrCfg = wordToCfg(busWdata);
    for (int i = 0; i < NUM_LINES; i++) begin
      strobe.cfgWr[i] = busWrEn & lineHit[i];
    end
  end

  always_comb begin
    busRdata = '0;
    if (statusHit) begin
      busRdata[NUM_LINES-1:0] = '1;
    end
    for (int i = 0; i < NUM_LINES; i++) begin
      if (lineHit[i]) begin
        busRdata = cfgToWord(cfgQ[i]);
      end
    end
  end

  // R9: a single bus write reaches at most one line
  a_r9_single_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.cfgWr));

  // R10: unmapped writes raise no strobe
  a_r10_unmapped_wr: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && !anyHit) |-> (strobe.cfgWr == '0));

  // R10: unmapped reads return zero
  a_r10_unmapped_rd: assert property (@(posedge clk) disable iff (!rstN)
    !anyHit |-> (busRdata == '0));

  // R3: status word holds its fixed ready pattern
  a_r3_status_value: assert property (@(posedge clk) disable iff (!rstN)
    statusHit |-> ($countones(busRdata) == NUM_LINES));

endmodule

// File: rtl/extirq_cond_dp.sv
module extirq_cond_dp
  import extirq_cond_pkg::*;
#(
  parameter int NUM_LINES   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobe_t              strobe,
  input  logic [NUM_LINES-1:0]     pinIn,
  output lineCfg_t [NUM_LINES-1:0] cfgQ,
  output logic [NUM_LINES-1:0]     irqOut
);

  // cycles since reset, saturating; used only by checks
  logic [1:0] warmCnt;
  always_ff @(posedge clk) begin
    if (!rstN)                warmCnt <= '0;
    else if (warmCnt != 2'd3) warmCnt <= warmCnt + 2'd1;
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic [SYNC_STAGES-1:0] syncQ;
    logic                   pinSync;
    logic                   invert;

    always_ff @(posedge clk) begin
      if (!rstN)                cfgQ[i] <= '0;
      else if (strobe.cfgWr[i]) cfgQ[i] <= strobe.wrCfg;
    end

    always_ff @(posedge clk) begin
      if (!rstN) syncQ <= '0;
      else       syncQ <= {syncQ[SYNC_STAGES-2:0], pinIn[i]};
    end

    assign pinSync   = syncQ[SYNC_STAGES-1];
    // level: polarity set means high-active; edge: polarity set means falling
    assign invert    = cfgQ[i].lvl ? ~cfgQ[i].pol : cfgQ[i].pol;
    assign irqOut[i] = cfgQ[i].en & (pinSync ^ invert);

    // R8: a disabled line never asserts
    a_r8_gate_low: assert property (@(posedge clk) disable iff (!rstN)
      !cfgQ[i].en |-> !irqOut[i]);

    // R9: register holds unless its own strobe fires
    a_r9_cfg_hold: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.cfgWr[i] |=> $stable(cfgQ[i]));

    // R2: register takes the written fields on its strobe
    a_r2_cfg_load: assert property (@(posedge clk) disable iff (!rstN)
      strobe.cfgWr[i] |=> (cfgQ[i] == $past(strobe.wrCfg)));

    if (SYNC_STAGES == 2) begin : g_lat
      // R11 / R4: active-high level shows the pin two edges late
      a_r11_latency: assert property (@(posedge clk) disable iff (!rstN)
        (warmCnt >= 2'd2 && cfgQ[i].en && cfgQ[i].lvl && cfgQ[i].pol)
          |-> (irqOut[i] == $past(pinIn[i], 2)));
    end
  end

  // R10: control never strobes a line that does not exist
  a_r10_strobe_range: assert property (@(posedge clk) disable iff (!rstN)
    (MAX_LINES'(strobe.cfgWr >> NUM_LINES) == '0));

endmodule

// File: rtl/extirq_cond.sv
module extirq_cond
  import extirq_cond_pkg::*;
#(
  parameter int NUM_LINES   = 2,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWrEn,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  input  logic [NUM_LINES-1:0] pinIn,
  output logic [NUM_LINES-1:0] irqOut
);

  ctrlStrobe_t              strobe;
  lineCfg_t [NUM_LINES-1:0] cfgQ;

  extirq_cond_ctrl #(
    .NUM_LINES(NUM_LINES),
    .ADDR_W   (ADDR_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busWrEn (busWrEn),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .cfgQ    (cfgQ),
    .strobe  (strobe),
    .busRdata(busRdata)
  );

  extirq_cond_dp #(
    .NUM_LINES  (NUM_LINES),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .pinIn (pinIn),
    .cfgQ  (cfgQ),
    .irqOut(irqOut)
  );

  initial begin
    a_r2_line_limit: assert (NUM_LINES >= 1 && NUM_LINES <= MAX_LINES);
    a_r11_sync_depth: assert (SYNC_STAGES >= 2);
  end

endmodule

// File: tb/extirq_cond_tb.sv
module extirq_cond_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [1:0]  pinIn = '0;
  logic [1:0]  irqOut;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  localparam logic [31:0] EN  = 32'h0001_0000;
  localparam logic [31:0] LVL = 32'h0000_0200;
  localparam logic [31:0] POL = 32'h0000_0100;

  always #5 clk = ~clk;

  extirq_cond u_dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn), .irqOut(irqOut)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdata;
  endtask

  // drive a pin on a falling edge, check latency of two rising edges
  task automatic pinStep(input int ln, input logic v, input logic expOut,
                         input string req);
    logic prev;
    @(negedge clk);
    prev = irqOut[ln];
    pinIn[ln] = v;
    @(negedge clk);
    check("R11", "output before second edge", 32'(irqOut[ln]), 32'(prev));
    @(negedge clk);
    check(req, "output after pin change", 32'(irqOut[ln]), 32'(expOut));
  endtask

  task automatic testReset();
    logic [31:0] d;
    rd(8'h04, d); check("R1", "line0 cfg after reset", d, 32'h0);
    rd(8'h08, d); check("R1", "line1 cfg after reset", d, 32'h0);
    check("R1", "outputs after reset", 32'(irqOut), 32'h0);
    rd(8'h00, d); check("R3", "status word", d, 32'h3);
  endtask

  task automatic testReadback();
    logic [31:0] d;
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, d); check("R2", "masked readback", d, EN | LVL | POL);
    wr(8'h04, LVL);
    rd(8'h04, d); check("R2", "level-only readback", d, LVL);
    wr(8'h04, 32'h0);
    rd(8'h04, d); check("R2", "cleared readback", d, 32'h0);
  endtask

  task automatic testStatusRO();
    logic [31:0] d;
    wr(8'h00, 32'h0);
    rd(8'h00, d); check("R3", "status after write", d, 32'h3);
    rd(8'h04, d); check("R3", "line0 untouched by status write", d, 32'h0);
  endtask

  task automatic testLevelHigh();
    wr(8'h04, EN | LVL | POL);
    pinStep(0, 1'b1, 1'b1, "R4");
    pinStep(0, 1'b0, 1'b0, "R4");
    wr(8'h04, 32'h0);
  endtask

  task automatic testLevelLow();
    wr(8'h08, EN | LVL);
    @(negedge clk);
    check("R5", "idle low pin asserts", 32'(irqOut[1]), 32'h1);
    pinStep(1, 1'b1, 1'b0, "R5");
    pinStep(1, 1'b0, 1'b1, "R5");
  endtask

  task automatic testDisable();
    logic [31:0] d;
    // line1 still active-low with pin low, output high
    wr(8'h08, LVL);
    check("R8", "output after enable cleared", 32'(irqOut[1]), 32'h0);
    rd(8'h08, d); check("R8", "readback after disable", d, LVL);
    pinStep(1, 1'b1, 1'b0, "R8");
    pinStep(1, 1'b0, 1'b0, "R8");
    wr(8'h08, 32'h0);
  endtask

  task automatic testEdgeRise();
    wr(8'h04, EN);
    pinStep(0, 1'b1, 1'b1, "R6");
    pinStep(0, 1'b0, 1'b0, "R6");
    wr(8'h04, 32'h0);
  endtask

  task automatic testEdgeFall();
    pinIn[1] = 1'b1;
    repeat (3) @(negedge clk);
    wr(8'h08, EN | POL);
    check("R7", "high pin gives low output", 32'(irqOut[1]), 32'h0);
    pinStep(1, 1'b0, 1'b1, "R7");
    pinStep(1, 1'b1, 1'b0, "R7");
    wr(8'h08, 32'h0);
    pinIn[1] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic testIndependent();
    logic [31:0] d;
    wr(8'h08, EN | LVL);
    check("R9", "line1 asserted", 32'(irqOut), 32'h2);
    wr(8'h04, EN | LVL | POL);
    rd(8'h08, d); check("R9", "line1 cfg after line0 write", d, EN | LVL);
    check("R9", "outputs after line0 write", 32'(irqOut), 32'h2);
    wr(8'h04, 32'h0);
    rd(8'h08, d); check("R9", "line1 cfg after line0 clear", d, EN | LVL);
  endtask

  task automatic testUnmapped();
    logic [31:0] d;
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h05, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF);
    rd(8'h0C, d); check("R10", "read 0x0C", d, 32'h0);
    rd(8'h05, d); check("R10", "read 0x05", d, 32'h0);
    rd(8'h40, d); check("R10", "read 0x40", d, 32'h0);
    rd(8'h04, d); check("R10", "line0 after stray writes", d, 32'h0);
    rd(8'h08, d); check("R10", "line1 after stray writes", d, EN | LVL);
    check("R10", "outputs after stray writes", 32'(irqOut), 32'h2);
    wr(8'h08, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testReadback();
    testStatusRO();
    testLevelHigh();
    testLevelLow();
    testDisable();
    testEdgeRise();
    testEdgeFall();
    testIndependent();
    testUnmapped();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule